// File: doc/BRIEF.md
# Scanline Pixel-Transfer Stall Calculator

For one display line, this block works out how many dots the pixel-transfer phase lasts. A pulse on `start` captures five things: the horizontal scroll value, whether the window opens on this line and at which X position, and the X positions and attribute-table indices of up to `N_OBJ` objects selected for the line. The block then handles one object per clock. It takes the objects in order of increasing X, and equal X values go in order of increasing index. It adds each object's stall to a running total. When every object has been handled, it raises `done` for one cycle. The saturated total appears on `dots` and stays there until the next run.

An uninterrupted line costs 172 dots: 160 pixels plus two initial tile fetches of 6 dots each. Three things add to that base:

- The fine part of the scroll (scroll mod 8) adds that many dots.
- An active window adds a flat 6 dots.
- Every object adds a 6-dot fetch. The first object to land on a given background or window tile also pays an alignment wait, which depends on where the object's leftmost pixel sits inside that 8-pixel tile.

A record of charged tiles, kept separately for background and window, makes sure each tile pays the alignment wait only once per line.

Top module: `pxs_stall_calc`

## Requirements
- R1: With no objects, no window and scroll 0, a run reports `dots` = 172.
- R2: Scroll bits [2:0] (scroll mod 8) are added once to the line length.
- R3: When `win_active` is 1, a flat 6 dots are added to the line length.
- R4: An object with X ≠ 0 lying over background costs 6 + max(0, 5 − off) dots, where off = ((X − 8 + scroll) mod 256) mod 8.
- R5: The alignment part of R4 is charged only to the first object processed on a given tile. The background tile number is ((X − 8 + scroll) mod 256) / 8. Every later object on that tile costs 6 dots.
- R6: An object with X = 0 costs exactly 11 dots whatever the scroll, and charges no tile.
- R7: When `win_active` is 1 and X > `win_x`, the object lies over the window. Its position is p = X − `win_x` − 1, with tile p/8 and offset p mod 8, and the scroll value plays no part. Window tiles are recorded separately from background tiles.
- R8: Objects are processed in increasing X order, with ties broken by the lower `obj_id`. The order decides which object pays a tile's alignment wait.
- R9: `dots` saturates at `MAX_DOTS` (default 289).
- R10: `done` is a single-cycle pulse. `dots` changes only with `done` and then holds. A `start` that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done` and `dots` are all 0.
- R12: Only the first `obj_count` entries of the object arrays take part. Entry i occupies bits [8i+7:8i] of `obj_x` and [6i+5:6i] of `obj_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin a line calculation |
| scroll_x | input | 8 | Horizontal background scroll |
| win_active | input | 1 | Window opens on this line |
| win_x | input | 8 | Window X position |
| obj_count | input | 4 | Number of valid object entries |
| obj_x | input | 80 | Packed object X positions, 8 bits each |
| obj_id | input | 60 | Packed object indices, 6 bits each |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when `dots` is updated |
| dots | output | 9 | Pixel-transfer length of the last line, in dots |

## Verification
The embedded properties check the following on every cycle:

- Processed object keys never decrease within a run.
- The charged-tile record only grows between clears.
- `done` never lasts two cycles.
- `dots` moves only together with `done`, and always lies between 172 and the cap.
- Captured inputs stay frozen during a run.

The actual stall arithmetic can only be shown by the bench scenarios. This covers the per-offset alignment cost, the once-per-tile charging, the window-relative tile mapping, the X = 0 exception, count masking, saturation, and the fact that a mid-run `start` is ignored.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int PIX_W         = 8;
  localparam int TILE_SHIFT    = 3;
  localparam int TILE_W        = PIX_W - TILE_SHIFT;
  localparam int N_TILES       = 1 << TILE_W;
  localparam int BASE_DOTS     = 172;
  localparam int FETCH_DOTS    = 6;
  localparam int WIN_DOTS      = 6;
  localparam int EDGE_OBJ_DOTS = 11;
  localparam int ALIGN_MAX     = 5;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

  typedef struct packed {
    logic              fixed;
    logic              on_win;
    logic [TILE_W-1:0] tile;
    logic [2:0]        align;
  } cost_t;
endpackage

// File: rtl/pxs_order_pick.sv
module pxs_order_pick
  import pxs_pkg::*;
#(
  parameter int N_OBJ = 10,
  parameter int IDX_W = 6,
  localparam int SEL_W = (N_OBJ > 1) ? $clog2(N_OBJ) : 1
) (
  input  logic [N_OBJ-1:0]       pend,
  input  logic [N_OBJ*PIX_W-1:0] xs,
  input  logic [N_OBJ*IDX_W-1:0] ids,
  output logic                   found,
  output logic [SEL_W-1:0]       sel
);
  localparam int KEY_W = PIX_W + IDX_W;

  logic [KEY_W-1:0] key [N_OBJ];

  genvar g;
  generate
    for (g = 0; g < N_OBJ; g++) begin : g_key
      assign key[g] = {xs[g*PIX_W +: PIX_W], ids[g*IDX_W +: IDX_W]};
    end
  endgenerate

  logic [KEY_W-1:0] best;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    best  = '0;
    for (int i = 0; i < N_OBJ; i++) begin
      if (pend[i] && (!found || key[i] < best)) begin
        found = 1'b1;
        sel   = SEL_W'(i);
        best  = key[i];
      end
    end
  end
endmodule

// File: rtl/pxs_obj_cost.sv
module pxs_obj_cost
  import pxs_pkg::*;
(
  input  logic [PIX_W-1:0] obj_x,
  input  logic [PIX_W-1:0] scroll,
  input  logic             win_en,
  input  logic [PIX_W-1:0] win_x,
  output cost_t            cost
);
  logic [PIX_W:0]   win_rel;
  logic [PIX_W-1:0] bg_pos;
  logic [PIX_W-1:0] pos;
  logic [2:0]       off;
  logic             over_win;

  always_comb begin
    win_rel  = {1'b0, obj_x} - {1'b0, win_x} - (PIX_W+1)'(1);
    bg_pos   = obj_x + scroll - PIX_W'(8);
    over_win = win_en && (obj_x > win_x);
    pos      = over_win ? win_rel[PIX_W-1:0] : bg_pos;
    off      = pos[TILE_SHIFT-1:0];

    cost.fixed  = (obj_x == '0);
    cost.on_win = over_win;
    cost.tile   = pos[PIX_W-1:TILE_SHIFT];
    cost.align  = (off <= 3'(ALIGN_MAX)) ? (3'(ALIGN_MAX) - off) : 3'd0;
  end
endmodule

// File: rtl/pxs_tile_ledger.sv
module pxs_tile_ledger
  import pxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mark,
  input  logic              on_win,
  input  logic [TILE_W-1:0] tile,
  output logic              seen
);
  logic [N_TILES-1:0] bank_q [2];
  logic [N_TILES-1:0] bank_d [2];

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      always_comb begin
        bank_d[b] = bank_q[b];
        if (clear) begin
          bank_d[b] = '0;
        end else if (mark && (on_win == b[0])) begin
          bank_d[b][tile] = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bank_q[b] <= '0;
        end else begin
          bank_q[b] <= bank_d[b];
        end
      end

      // R5: a charged tile stays charged until the next line clears the record
      a_r5_ledger_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((bank_q[b] & $past(bank_q[b])) == $past(bank_q[b])));
    end
  endgenerate

  assign seen = on_win ? bank_q[1][tile] : bank_q[0][tile];
endmodule

// File: rtl/pxs_stall_calc.sv
module pxs_stall_calc
  import pxs_pkg::*;
#(
  parameter int N_OBJ    = 10,
  parameter int IDX_W    = 6,
  parameter int MAX_DOTS = 289,
  localparam int CNT_W   = $clog2(N_OBJ + 1),
  localparam int LEN_W   = $clog2(MAX_DOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [PIX_W-1:0]       scroll_x,
  input  logic                   win_active,
  input  logic [PIX_W-1:0]       win_x,
  input  logic [CNT_W-1:0]       obj_count,
  input  logic [N_OBJ*PIX_W-1:0] obj_x,
  input  logic [N_OBJ*IDX_W-1:0] obj_id,
  output logic                   busy,
  output logic                   done,
  output logic [LEN_W-1:0]       dots
);
  localparam int SEL_W   = (N_OBJ > 1) ? $clog2(N_OBJ) : 1;
  localparam int KEY_W   = PIX_W + IDX_W;
  localparam int ACC_MAX = BASE_DOTS + 7 + WIN_DOTS + N_OBJ * EDGE_OBJ_DOTS;
  localparam int ACC_W   = $clog2(ACC_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // captured line parameters (enable only, no reset)
  logic                   cap_en;
  logic [PIX_W-1:0]       scx_q, wx_q;
  logic                   win_q;
  logic [N_OBJ*PIX_W-1:0] xs_q;
  logic [N_OBJ*IDX_W-1:0] ids_q;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      scx_q <= scroll_x;
      wx_q  <= win_x;
      win_q <= win_active;
      xs_q  <= obj_x;
      ids_q <= obj_id;
    end
  end

  // control state
  st_e                st_q, st_d;
  logic [N_OBJ-1:0]   pend_q, pend_d;
  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [LEN_W-1:0]   dots_q, dots_d;
  logic               done_q, done_d;
  logic [KEY_W-1:0]   last_q, last_d;
  logic               have_last_q, have_last_d;

  logic               found;
  logic [SEL_W-1:0]   sel;
  logic [PIX_W-1:0]   sel_x;
  logic [KEY_W-1:0]   sel_key;
  cost_t              cst;
  logic               seen;
  logic               led_clear, led_mark;
  logic [3:0]         step;

  pxs_order_pick #(.N_OBJ(N_OBJ), .IDX_W(IDX_W)) u_pick (
    .pend  (pend_q),
    .xs    (xs_q),
    .ids   (ids_q),
    .found (found),
    .sel   (sel)
  );

  assign sel_x   = xs_q[sel*PIX_W +: PIX_W];
  assign sel_key = {sel_x, ids_q[sel*IDX_W +: IDX_W]};

  pxs_obj_cost u_cost (
    .obj_x  (sel_x),
    .scroll (scx_q),
    .win_en (win_q),
    .win_x  (wx_q),
    .cost   (cst)
  );

  pxs_tile_ledger u_ledger (
    .clk    (clk),
    .rst_n  (rst_i),
    .clear  (led_clear),
    .mark   (led_mark),
    .on_win (cst.on_win),
    .tile   (cst.tile),
    .seen   (seen)
  );

  always_comb begin
    if (cst.fixed) step = 4'(EDGE_OBJ_DOTS);
    else           step = 4'(FETCH_DOTS) + (seen ? 4'd0 : {1'b0, cst.align});
  end

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    acc_d       = acc_q;
    dots_d      = dots_q;
    done_d      = 1'b0;
    last_d      = last_q;
    have_last_d = have_last_q;
    cap_en      = 1'b0;
    led_clear   = 1'b0;
    led_mark    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d        = ST_RUN;
          cap_en      = 1'b1;
          led_clear   = 1'b1;
          have_last_d = 1'b0;
          acc_d       = ACC_W'(BASE_DOTS) + ACC_W'(scroll_x[TILE_SHIFT-1:0])
                      + (win_active ? ACC_W'(WIN_DOTS) : '0);
          for (int i = 0; i < N_OBJ; i++) begin
            pend_d[i] = (CNT_W'(i) < obj_count);
          end
        end
      end
      default: begin
        if (found) begin
          acc_d       = acc_q + ACC_W'(step);
          pend_d[sel] = 1'b0;
          led_mark    = !cst.fixed;
          last_d      = sel_key;
          have_last_d = 1'b1;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          dots_d = (acc_q > ACC_W'(MAX_DOTS)) ? LEN_W'(MAX_DOTS) : LEN_W'(acc_q);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q        <= ST_IDLE;
      pend_q      <= '0;
      acc_q       <= '0;
      dots_q      <= '0;
      done_q      <= 1'b0;
      last_q      <= '0;
      have_last_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_q      <= pend_d;
      acc_q       <= acc_d;
      dots_q      <= dots_d;
      done_q      <= done_d;
      last_q      <= last_d;
      have_last_q <= have_last_d;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;
  assign dots = dots_q;

  // R8: objects leave the queue in non-decreasing (X, index) order
  a_r8_order_monotonic: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_RUN) && found && have_last_q |-> (sel_key >= last_q));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    done_q |=> !done_q);

  // R10: the reported length moves only together with done
  a_r10_dots_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(dots_q) |-> done_q);

  // R10: captured inputs stay frozen while a run is in progress
  a_r10_capture_frozen: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_RUN) |=> ($stable(scx_q) && $stable(xs_q) && $stable(wx_q)));

  // R9 / R1: a published length lies between the base line and the cap
  a_r9_dots_range: assert property (@(posedge clk) disable iff (!rst_i)
    done_q |-> (dots_q <= LEN_W'(MAX_DOTS)) && (dots_q >= LEN_W'(BASE_DOTS)));
endmodule

// File: tb/pxs_stall_calc_tb.sv
`timescale 1ns/1ps
module pxs_stall_calc_tb;
  localparam int N  = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  scroll_x;
  logic        win_active;
  logic [7:0]  win_x;
  logic [3:0]  obj_count;
  logic [79:0] obj_x;
  logic [59:0] obj_id;
  logic        busy, done;
  logic [8:0]  dots;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pxs_stall_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scroll_x(scroll_x),
    .win_active(win_active), .win_x(win_x), .obj_count(obj_count),
    .obj_x(obj_x), .obj_id(obj_id), .busy(busy), .done(done), .dots(dots)
  );

  // {scroll, win, win_x, count, x0, x1, x2, x3, expected}
  localparam logic [61:0] VEC [NV] = '{
    {8'd0,  1'b0, 8'd0,  4'd0, 8'd0,  8'd0,  8'd0, 8'd0,  9'd172},
    {8'd13, 1'b0, 8'd0,  4'd0, 8'd0,  8'd0,  8'd0, 8'd0,  9'd177},
    {8'd0,  1'b1, 8'd50, 4'd0, 8'd0,  8'd0,  8'd0, 8'd0,  9'd178},
    {8'd0,  1'b0, 8'd0,  4'd1, 8'd8,  8'd0,  8'd0, 8'd0,  9'd183},
    {8'd0,  1'b0, 8'd0,  4'd1, 8'd15, 8'd0,  8'd0, 8'd0,  9'd178},
    {8'd3,  1'b0, 8'd0,  4'd1, 8'd8,  8'd0,  8'd0, 8'd0,  9'd183},
    {8'd0,  1'b0, 8'd0,  4'd2, 8'd8,  8'd10, 8'd0, 8'd0,  9'd189},
    {8'd0,  1'b0, 8'd0,  4'd2, 8'd8,  8'd16, 8'd0, 8'd0,  9'd194},
    {8'd0,  1'b0, 8'd0,  4'd2, 8'd12, 8'd8,  8'd0, 8'd0,  9'd189},
    {8'd5,  1'b0, 8'd0,  4'd2, 8'd0,  8'd3,  8'd0, 8'd0,  9'd199},
    {8'd0,  1'b1, 8'd20, 4'd1, 8'd24, 8'd0,  8'd0, 8'd0,  9'd186},
    {8'd0,  1'b1, 8'd20, 4'd2, 8'd10, 8'd21, 8'd0, 8'd0,  9'd198},
    {8'd0,  1'b0, 8'd0,  4'd1, 8'd8,  8'd16, 8'd0, 8'd0,  9'd183},
    {8'd2,  1'b0, 8'd0,  4'd1, 8'd11, 8'd0,  8'd0, 8'd0,  9'd180},
    {8'd6,  1'b0, 8'd0,  4'd4, 8'd40, 8'd9,  8'd9, 8'd44, 9'd205}
  };
  localparam string VTAG [NV] = '{
    "R1", "R2", "R3", "R4", "R4", "R4", "R5", "R5",
    "R8", "R6", "R7", "R7", "R12", "R4", "R8"
  };

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic kick(input logic [7:0] s, input logic w, input logic [7:0] wx,
                      input logic [3:0] cnt, input logic [79:0] xs);
    @(negedge clk);
    scroll_x = s; win_active = w; win_x = wx; obj_count = cnt; obj_x = xs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL %s: got no done expected done pulse", tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; scroll_x = '0; win_active = 1'b0;
    win_x = '0; obj_count = '0; obj_x = '0;
    for (int i = 0; i < N; i++) obj_id[i*6 +: 6] = 6'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    check("R11 busy", {8'd0, busy}, 9'd0);
    check("R11 done", {8'd0, done}, 9'd0);
    check("R11 dots", dots, 9'd0);

    for (int v = 0; v < NV; v++) begin
      kick(VEC[v][61:54], VEC[v][53], VEC[v][52:45], VEC[v][44:41],
           {48'd0, VEC[v][16:9], VEC[v][24:17], VEC[v][32:25], VEC[v][40:33]});
      wait_done(VTAG[v]);
      check(VTAG[v], dots, VEC[v][8:0]);
    end

    // R9: ten edge objects with full scroll and window exceed the cap
    kick(8'd7, 1'b1, 8'd255, 4'd10, 80'd0);
    wait_done("R9");
    check("R9 saturate", dots, 9'd289);

    // R6: ten edge objects, no extras -> 172 + 110
    kick(8'd0, 1'b0, 8'd0, 4'd10, 80'd0);
    // R10: a start while busy must be ignored
    @(negedge clk);
    scroll_x = 8'd7; win_active = 1'b1; obj_count = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    check("R10 ignore start while busy", dots, 9'd282);
    @(negedge clk);
    check("R10 done pulse width", {8'd0, done}, 9'd0);
    repeat (5) @(negedge clk);
    check("R10 dots hold", dots, 9'd282);
    check("R10 idle after run", {8'd0, busy}, 9'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule